// File: doc/BRIEF.md
# Phase Detector with Lock Monitor

This block is the digital core of a synthesizer's phase comparison path. A fast sampling clock watches two divided pulse trains: one from the reference divider and one from the main divider. The rising edge of each pulse is one arrival. When the reference arrives first, the block raises an UP request to the external charge pump. When the main pulse arrives first, it raises a DOWN request. Both requests are released together as soon as the other edge also arrives. When both edges arrive in the same sampling cycle, neither request is raised.

For every comparison, the block measures in sampling cycles how long a request was held. It treats that length as the phase error. Lock is declared only after a run of seven comparisons in a row whose error stays below a time threshold. The threshold is set in nanoseconds and converted to cycles from the clock period.

A disable input stops the pump and clears the lock verdict. A 2-bit pump level code is loaded from the configuration side on a transfer-complete strobe. The new code is passed to the pump only while no request is active, so the pump current never changes in the middle of a correction pulse.

Top module: `pfd_lock_monitor`

## Requirements
- R1: During and right after reset, `pump_up`, `pump_dn`, `pump_act` and `lock_ok` are 0 and `lvl_code` is 2'b00.
- R2: If the reference rise comes d ≥ 1 sampling cycles before the main rise, `pump_up` is high for exactly d cycles, starting on the clock edge that samples the reference rise, and `pump_dn` stays low.
- R3: If the main rise comes d ≥ 1 cycles before the reference rise, `pump_dn` is high for exactly d cycles and `pump_up` stays low.
- R4: Rises of both pulses in the same sampling cycle raise neither `pump_up` nor `pump_dn`.
- R5: `pump_up` and `pump_dn` are never high in the same cycle.
- R6: A comparison is good when its request width in cycles is below THR = LOCK_NS / CLK_NS (25 by default). `lock_ok` goes high on the edge that completes the seventh consecutive good comparison, and not earlier.
- R7: A comparison whose width is THR or more restarts the good run and drops `lock_ok` on the edge that completes it.
- R8: While `pump_off` is high, `pump_up`, `pump_dn` and `lock_ok` are 0 from the next edge on, and the good run restarts from zero.
- R9: `lvl_sel` is captured only on a cycle with `cfg_done` high. Changes to `lvl_sel` at any other time leave `lvl_code` unchanged. The codes run from 00 (lowest current) to 11 (highest).
- R10: A captured level reaches `lvl_code` on the first edge after capture at which no request was active. While a request is active, `lvl_code` holds.
- R11: `pump_act` is high exactly when `pump_up` or `pump_dn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Divided reference pulse, synchronous to clk |
| main_pulse | input | 1 | Divided main (VCO) pulse, synchronous to clk |
| pump_off | input | 1 | Disables the pump and the lock verdict |
| lvl_sel | input | 2 | Requested pump current level |
| cfg_done | input | 1 | One-cycle strobe marking a completed configuration transfer |
| pump_up | output | 1 | Source-current request |
| pump_dn | output | 1 | Sink-current request |
| pump_act | output | 1 | Either request is active |
| lvl_code | output | 2 | Pump current level in use |
| lock_ok | output | 1 | Loop judged locked |

## Verification
A corrupted width counter appears first in `lock_ok`. It rises a comparison early or late, or it fails to fall on the comparison that reaches THR cycles, so the bench sweeps the lead from 0 to beyond THR in both directions. A stuck request state shows as a request width that differs from the lead by at least one cycle in the very comparison where it occurs. A level register that loads at the wrong moment shows `lvl_code` moving while a request is active, or moving without a strobe. In either case the error is visible within two edges.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Width of the per-comparison error measurement; it saturates at its maximum.
    localparam int MEAS_W = 8;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_MIDLO = 2'b01,
        LVL_MIDHI = 2'b10,
        LVL_HIGH  = 2'b11
    } pump_lvl_t;

    typedef struct packed {
        logic              done;   // comparison completes on this edge
        logic [MEAS_W-1:0] width;  // request width in cycles for that comparison
    } cmp_t;

    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = ns / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic logic [MEAS_W-1:0] sat_inc(input logic [MEAS_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic main_pulse,
    input  logic hold,
    output logic up,
    output logic dn,
    output cmp_t res
);
    logic ref_q, main_q;
    logic ref_rise, main_rise;
    logic arm_up, arm_dn, both;
    logic [MEAS_W-1:0] wcnt;

    assign ref_rise  = ref_pulse & ~ref_q;
    assign main_rise = main_pulse & ~main_q;
    assign arm_up    = up | ref_rise;
    assign arm_dn    = dn | main_rise;
    assign both      = arm_up & arm_dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= 1'b0;
            main_q <= 1'b0;
            up     <= 1'b0;
            dn     <= 1'b0;
            wcnt   <= '0;
        end else begin
            ref_q  <= ref_pulse;
            main_q <= main_pulse;
            if (hold || both) begin
                up   <= 1'b0;
                dn   <= 1'b0;
                wcnt <= '0;
            end else begin
                up <= arm_up;
                dn <= arm_dn;
                if (up || dn)
                    wcnt <= sat_inc(wcnt);
            end
        end
    end

    always_comb begin
        res.done  = both & ~hold;
        res.width = (up || dn) ? sat_inc(wcnt) : wcnt;
    end
endmodule

// File: rtl/lock_judge.sv
module lock_judge
    import pfd_pkg::*;
#(
    parameter int unsigned THR      = 25,
    parameter int unsigned LOCK_RUN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  cmp_t res,
    output logic locked
);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_RUN);

    logic [RW-1:0] run;
    logic [RW-1:0] run_nxt;
    logic          good;

    assign good    = (32'(res.width) < THR);
    assign run_nxt = (run == RUN_MAX) ? run : run + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            run    <= '0;
            locked <= 1'b0;
        end else if (res.done) begin
            if (good) begin
                run    <= run_nxt;
                locked <= (run_nxt == RUN_MAX);
            end else begin
                run    <= '0;
                locked <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/level_sync.sv
module level_sync
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] sel,
    input  logic       busy,
    output pump_lvl_t  code
);
    pump_lvl_t pend;
    logic      pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            code   <= LVL_LOW;
            pend   <= LVL_LOW;
            pend_v <= 1'b0;
        end else if (load) begin
            pend   <= pump_lvl_t'(sel);
            pend_v <= 1'b1;
        end else if (pend_v && !busy) begin
            code   <= pend;
            pend_v <= 1'b0;
        end
    end
endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
    import pfd_pkg::*;
#(
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned LOCK_NS  = 250,
    parameter int unsigned LOCK_RUN = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_pulse,
    input  logic       main_pulse,
    input  logic       pump_off,
    input  logic [1:0] lvl_sel,
    input  logic       cfg_done,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_act,
    output logic [1:0] lvl_code,
    output logic       lock_ok
);
    localparam int unsigned THR = ns_to_cycles(LOCK_NS, CLK_NS);

    cmp_t      res;
    pump_lvl_t lvl;

    pfd_core u_core (
        .clk        (clk),
        .rst        (rst),
        .ref_pulse  (ref_pulse),
        .main_pulse (main_pulse),
        .hold       (pump_off),
        .up         (pump_up),
        .dn         (pump_dn),
        .res        (res)
    );

    lock_judge #(.THR(THR), .LOCK_RUN(LOCK_RUN)) u_judge (
        .clk    (clk),
        .rst    (rst),
        .hold   (pump_off),
        .res    (res),
        .locked (lock_ok)
    );

    level_sync u_lvl (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_done),
        .sel  (lvl_sel),
        .busy (pump_act),
        .code (lvl)
    );

    assign pump_act = pump_up | pump_dn;
    assign lvl_code = lvl;
endmodule

// File: rtl/pfd_lock_monitor_chk.sv
module pfd_lock_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       pump_off,
    input logic       pump_up,
    input logic       pump_dn,
    input logic [1:0] lvl_code,
    input logic       lock_ok
);
    p_never_both_r5: assert property (@(posedge clk) disable iff (rst)
        !(pump_up && pump_dn));

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        pump_off |=> (!pump_up && !pump_dn && !lock_ok));

    p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pump_up || pump_dn) |=> $stable(lvl_code));

    p_lock_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_ok) |-> !$past(pump_off));
endmodule

bind pfd_lock_monitor pfd_lock_monitor_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pump_off (pump_off),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .lvl_code (lvl_code),
    .lock_ok  (lock_ok)
);

// File: tb/sim_pfd_lock_monitor.sv
module sim_pfd_lock_monitor;
    localparam int CLK_P = 10;
    localparam int THR   = 250 / CLK_P;
    localparam int RUN   = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pulse = 1'b0, main_pulse = 1'b0, pump_off = 1'b0, cfg_done = 1'b0;
    logic [1:0] lvl_sel = 2'b00;
    logic pump_up, pump_dn, pump_act, lock_ok;
    logic [1:0] lvl_code;

    int checks = 0;
    int errors = 0;
    int run_m = 0;

    always #(CLK_P/2) clk = ~clk;

    pfd_lock_monitor u0 (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .main_pulse(main_pulse),
        .pump_off(pump_off), .lvl_sel(lvl_sel), .cfg_done(cfg_done),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_act(pump_act),
        .lvl_code(lvl_code), .lock_ok(lock_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Updates the bench's lock model after one comparison of lead d.
    task automatic model_lock(input int d);
        if (pump_off) run_m = 0;
        else if (d < THR) run_m = (run_m < RUN) ? run_m + 1 : RUN;
        else run_m = 0;
    endtask

    // One comparison: the leading pulse rises, the other follows d cycles later.
    task automatic run_cmp(input bit ref_leads, input int d);
        int n_up = 0, n_dn = 0, both = 0, act_bad = 0;
        int exp_up, exp_dn;
        @(negedge clk);
        if (ref_leads) ref_pulse = 1'b1; else main_pulse = 1'b1;
        if (d == 0) begin ref_pulse = 1'b1; main_pulse = 1'b1; end
        for (int i = 1; i <= d + 3; i++) begin
            @(negedge clk);
            if (pump_up) n_up++;
            if (pump_dn) n_dn++;
            if (pump_up && pump_dn) both++;
            if (pump_act != (pump_up | pump_dn)) act_bad++;
            if (i == d) begin ref_pulse = 1'b1; main_pulse = 1'b1; end
        end
        exp_up = (pump_off || !ref_leads) ? 0 : d;
        exp_dn = (pump_off || ref_leads) ? 0 : d;
        if (d == 0) chk(n_up == 0 && n_dn == 0, "R4 aligned", n_up + n_dn, 0);
        else if (ref_leads) chk(n_up == exp_up && n_dn == 0, "R2 up width", n_up, exp_up);
        else chk(n_dn == exp_dn && n_up == 0, "R3 dn width", n_dn, exp_dn);
        chk(both == 0, "R5 both high", both, 0);
        chk(act_bad == 0, "R11 pump_act", act_bad, 0);
        model_lock(d);
        if (d >= THR && !pump_off)
            chk(lock_ok == 1'b0, "R7 drop on wide", lock_ok, 0);
        else
            chk(lock_ok == (run_m == RUN), "R6 lock run", lock_ok, run_m == RUN);
        ref_pulse = 1'b0; main_pulse = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(pump_up == 0 && pump_dn == 0 && pump_act == 0, "R1 reset pump", pump_up + pump_dn, 0);
        chk(lock_ok == 0 && lvl_code == 2'b00, "R1 reset lock/code", lvl_code, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(lock_ok == 0 && lvl_code == 2'b00 && !pump_act, "R1 after release", lvl_code, 0);

        // Sweep leads across the threshold, both directions.
        for (int d = 0; d <= THR + 2; d++) run_cmp(1'b1, d);
        for (int d = 0; d <= THR + 2; d++) run_cmp(1'b0, d);

        // Exact run length: six goods are not enough, seventh locks, THR-1 still good.
        run_cmp(1'b1, THR);
        for (int k = 0; k < RUN - 1; k++) run_cmp(1'b0, 2);
        chk(lock_ok == 0, "R6 six goods", lock_ok, 0);
        run_cmp(1'b1, THR - 1);
        chk(lock_ok == 1, "R6 seventh good", lock_ok, 1);
        run_cmp(1'b0, THR);
        chk(lock_ok == 0, "R7 wide comparison", lock_ok, 0);

        // Disable: pump quiet, lock cleared.
        for (int k = 0; k < RUN; k++) run_cmp(1'b1, 1);
        @(negedge clk); pump_off = 1'b1;
        @(negedge clk);
        chk(lock_ok == 0, "R8 lock cleared", lock_ok, 0);
        run_cmp(1'b1, 5);
        run_cmp(1'b0, 5);
        pump_off = 1'b0;
        @(negedge clk);
        run_m = 0;

        // Level code: no strobe, no change.
        lvl_sel = 2'b10;
        repeat (4) @(negedge clk);
        chk(lvl_code == 2'b00, "R9 sel without strobe", lvl_code, 0);
        cfg_done = 1'b1;
        @(negedge clk); cfg_done = 1'b0; lvl_sel = 2'b01;
        @(negedge clk);
        chk(lvl_code == 2'b10, "R9 load on strobe idle", lvl_code, 2);
        repeat (3) @(negedge clk);
        chk(lvl_code == 2'b10, "R9 later sel ignored", lvl_code, 2);

        // Level code: strobe during an active request is deferred.
        ref_pulse = 1'b1;
        repeat (3) @(negedge clk);
        lvl_sel = 2'b11; cfg_done = 1'b1;
        @(negedge clk); cfg_done = 1'b0;
        repeat (2) @(negedge clk);
        chk(pump_up == 1 && lvl_code == 2'b10, "R10 held while active", lvl_code, 2);
        repeat (4) @(negedge clk);
        main_pulse = 1'b1;
        repeat (3) @(negedge clk);
        chk(lvl_code == 2'b11, "R10 applied after idle", lvl_code, 3);
        ref_pulse = 1'b0; main_pulse = 1'b0;
        repeat (3) @(negedge clk);

        report();
    end
endmodule